// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides its input clock by a programmable integer ratio. The counting is done by three parts. A prescaler is modelled as plain digital logic and divides by either P or P+1. A swallow counter decides, for every prescaler cycle, which of those two moduli is in force. A main counter counts prescaler cycles until the output period ends. In each output period the prescaler runs A cycles at P+1 and the remaining cycles at P. The total ratio is therefore N = P·M + A, so every integer ratio can be reached, not only multiples of P.

The divided output is a single-cycle pulse. It feeds a phase comparator and can also serve as a monitor of the comparison signal. The modulus-control state is brought out as a separate signal.

The setting and the prescaler select arrive already latched from outside the block. The block takes them in only when a period ends, so a new value never cuts a period short.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rstN` is low, `divPulse` and `modCtl` are both 0.
- R2: The setting word carries the swallow value A in its low SWALLOW_W bits (bits 6:0 by default) and the main value M in the MAIN_W bits above them (bits 17:7 by default).
- R3: With `presSel` = 1 the prescaler base modulus P is 2^PRE_LO_LOG2 (32 by default). With `presSel` = 0 it is 2^PRE_HI_LOG2 (64 by default). The swallowing modulus is P+1 in both cases.
- R4: For 1 ≤ A ≤ M, or for A = 0 with M ≥ 1, consecutive `divPulse` pulses are exactly N = P·M + A input cycles apart.
- R5: `divPulse` is high for exactly one input cycle per output period.
- R6: In every output period `modCtl` is high for exactly A·(P+1) input cycles, which are the first cycles of the period. It is low for the rest of the period.
- R7: A change of `setting` or `presSel` during a period does not alter that period. The new values govern the period that starts at the next pulse.
- R8: When A > M ≥ 1, the period is M·(P+1) cycles and `modCtl` stays high for all of it.
- R9: A main value M = 0 behaves exactly as M = 1, so the period is P + min(A,1) cycles.
- R10: The first rising edge with `rstN` high loads the setting. The first `divPulse` appears N cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Active-low synchronous reset |
| presSel | input | 1 | Prescaler select: 1 picks the smaller base modulus, 0 the larger |
| setting | input | SWALLOW_W+MAIN_W | Latched divide setting {M, A} |
| divPulse | output | 1 | One-cycle pulse at the end of each output period |
| modCtl | output | 1 | High while the prescaler divides by P+1 |

## Verification
The bench builds the block with a 3-bit swallow field, a 4-bit main field and prescaler moduli of 4/5 and 8/9. With these values all 256 combinations of select, M and A can be swept, including the A > M and M = 0 corner cases, at a few dozen cycles per period. Every combination is entered in the middle of a running period. This checks that the period in progress keeps its old length and that the next period measures exactly P·M + A, with the modulus-control high time counted alongside.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic reload;   // load both counters and the select from the inputs
    logic tick;     // prescaler completes one cycle
  } psdStrobe_t;

  // Status from the datapath back to the control
  typedef struct packed {
    logic swallowBusy;  // swallow counter nonzero: prescaler runs at P+1
    logic mainLast;     // main counter at its final prescaler cycle
    logic smallMod;     // latched select: smaller base modulus
  } psdStatus_t;

endpackage

// File: rtl/psd_loadcnt.sv
module psd_loadcnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - W'(1);
    end
  end

  // R7: with no strobe the count holds its value
  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !dec) |=> $stable(cnt));

  // R4: between loads the count never grows
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!load) |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/psd_dpath.sv
module psd_dpath
  import psd_pkg::*;
#(
  parameter int SWALLOW_W = 7,
  parameter int MAIN_W    = 11,
  localparam int SET_W    = SWALLOW_W + MAIN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  psdStrobe_t       strobe,
  input  logic             presSel,
  input  logic [SET_W-1:0] setting,
  output psdStatus_t       status
);

  logic [SWALLOW_W-1:0] swallowCnt;
  logic [MAIN_W-1:0]    mainCnt;
  logic                 selQ;
  logic                 swallowDec;

  assign swallowDec = strobe.tick && (swallowCnt != '0);

  psd_loadcnt #(.W(SWALLOW_W)) uSwallow (
    .clk     (clk),
    .rstN    (rstN),
    .load    (strobe.reload),
    .dec     (swallowDec),
    .loadVal (setting[SWALLOW_W-1:0]),
    .cnt     (swallowCnt)
  );

  psd_loadcnt #(.W(MAIN_W)) uMain (
    .clk     (clk),
    .rstN    (rstN),
    .load    (strobe.reload),
    .dec     (strobe.tick),
    .loadVal (setting[SET_W-1:SWALLOW_W]),
    .cnt     (mainCnt)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= 1'b0;
    end else if (strobe.reload) begin
      selQ <= presSel;
    end
  end

  assign status.swallowBusy = (swallowCnt != '0);
  assign status.mainLast    = (mainCnt <= MAIN_W'(1));
  assign status.smallMod    = selQ;

  // R7: the select is only taken at a reload
  a_r7_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.reload) |=> $stable(selQ));

  // R6: swallowing ends only at the end of a prescaler cycle
  a_r6_swallow_ends_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status.swallowBusy) |-> $past(strobe.tick));

endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int PRE_LO_LOG2 = 5,
  parameter int PRE_HI_LOG2 = 6,
  localparam int PCNT_W     = PRE_HI_LOG2 + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  psdStatus_t status,
  output psdStrobe_t strobe,
  output logic       divPulse
);

  logic [PCNT_W-1:0] preCnt;
  logic [PCNT_W-1:0] preBase;
  logic [PCNT_W-1:0] termVal;
  logic              armed;
  logic              periodEnd;

  assign preBase = status.smallMod ? (PCNT_W'(1) << PRE_LO_LOG2)
                                   : (PCNT_W'(1) << PRE_HI_LOG2);
  // last count of the current prescaler cycle: P-1, or P when swallowing
  assign termVal = preBase + PCNT_W'(status.swallowBusy) - PCNT_W'(1);

  assign strobe.tick   = armed && (preCnt == termVal);
  assign periodEnd     = strobe.tick && status.mainLast;
  assign strobe.reload = !armed || periodEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      armed    <= 1'b0;
      divPulse <= 1'b0;
    end else begin
      armed    <= 1'b1;
      divPulse <= periodEnd;
      if (strobe.reload || strobe.tick) begin
        preCnt <= '0;
      end else begin
        preCnt <= preCnt + PCNT_W'(1);
      end
    end
  end

  // R5: the output pulse lasts a single cycle
  a_r5_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R4: the prescaler count stays within the active modulus
  a_r4_prescaler_bound: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (preCnt <= termVal));

  // R4: a pulse follows only the final main-counter cycle
  a_r4_pulse_after_last: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> $past(status.mainLast));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int SWALLOW_W   = 7,
  parameter int MAIN_W      = 11,
  parameter int PRE_LO_LOG2 = 5,
  parameter int PRE_HI_LOG2 = 6,
  localparam int SET_W      = SWALLOW_W + MAIN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             presSel,
  input  logic [SET_W-1:0] setting,
  output logic             divPulse,
  output logic             modCtl
);

  psdStrobe_t strobe;
  psdStatus_t status;

  psd_ctrl #(
    .PRE_LO_LOG2 (PRE_LO_LOG2),
    .PRE_HI_LOG2 (PRE_HI_LOG2)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .status   (status),
    .strobe   (strobe),
    .divPulse (divPulse)
  );

  psd_dpath #(
    .SWALLOW_W (SWALLOW_W),
    .MAIN_W    (MAIN_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .presSel (presSel),
    .setting (setting),
    .status  (status)
  );

  assign modCtl = status.swallowBusy;

  // R1: quiet outputs while reset is applied (checked once reset has been seen)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!divPulse || $isunknown(divPulse));
    end
  end

endmodule

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;

  localparam int SW_W = 3;
  localparam int MN_W = 4;
  localparam int LO_L = 2;
  localparam int HI_L = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              presSel = 1'b1;
  logic [SW_W+MN_W-1:0] setting = '0;
  logic              divPulse;
  logic              modCtl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pulse_swallow_div #(
    .SWALLOW_W   (SW_W),
    .MAIN_W      (MN_W),
    .PRE_LO_LOG2 (LO_L),
    .PRE_HI_LOG2 (HI_L)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .presSel  (presSel),
    .setting  (setting),
    .divPulse (divPulse),
    .modCtl   (modCtl)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int periodLen(input bit sel, input int m, input int a);
    int p    = sel ? (1 << LO_L) : (1 << HI_L);
    int mEff = (m == 0) ? 1 : m;
    int aEff = (a < mEff) ? a : mEff;
    return p * mEff + aEff;
  endfunction

  function automatic int modHighLen(input bit sel, input int m, input int a);
    int p    = sel ? (1 << LO_L) : (1 << HI_L);
    int mEff = (m == 0) ? 1 : m;
    int aEff = (a < mEff) ? a : mEff;
    return aEff * (p + 1);
  endfunction

  // Called at the negedge that shows a pulse; returns at the next pulse sample.
  task automatic measure(output int n, output int mh, output int widthBad);
    mh = modCtl ? 1 : 0;
    n = 0;
    widthBad = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1 && divPulse) widthBad = 1;
      if (divPulse || n > 2000) break;
      if (modCtl) mh++;
    end
  endtask

  initial begin
    int n, mh, wb;
    presSel = 1'b1;
    setting = {4'd5, 3'd3};
    repeat (3) begin
      @(negedge clk);
      check("R1 divPulse in reset", int'(divPulse), 0);
      check("R1 modCtl in reset", int'(modCtl), 0);
    end
    rstN = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (divPulse || n > 2000) break;
    end
    // first sample after the loading edge is n=1, pulse shows after edge N
    check("R10 first pulse delay", n, periodLen(1'b1, 5, 3) + 1);

    begin
      bit prevSel = 1'b1;
      int prevM = 5;
      int prevA = 3;
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < (1 << MN_W); m++) begin
          for (int a = 0; a < (1 << SW_W); a++) begin
            // change mid-period: the running period keeps the old ratio (R7)
            presSel = s[0];
            setting = {m[MN_W-1:0], a[SW_W-1:0]};   // R2: {M, A}
            measure(n, mh, wb);
            check("R7 running period unchanged", n, periodLen(prevSel, prevM, prevA));
            check("R5 pulse width", wb, 0);
            measure(n, mh, wb);
            if (m == 0)
              check("R9 zero main value", n, periodLen(s[0], 1, a));
            else if (a > m)
              check("R8 swallow exceeds main", n, m * ((s[0] ? (1 << LO_L) : (1 << HI_L)) + 1));
            else
              check("R4 R3 period length", n, periodLen(s[0], m, a));
            check("R6 modCtl high time", mh, modHighLen(s[0], m, a));
            check("R5 pulse width", wb, 0);
            prevSel = s[0];
            prevM = m;
            prevA = a;
          end
        end
      end
    end
    summary();
    $finish;
  end

endmodule